// File: doc/BRIEF.md
# Accumulator Execution Unit

This block is one execution unit of a processor in which every register has its own unit and all units run in parallel. It holds a W-bit accumulator, a carry flag and a zero flag. In each clock cycle it takes one decoded data-manipulation instruction on unsigned integers, computes a result from the accumulator and a second operand, and writes the accumulator and the flags according to three write enables carried in the instruction.

The second operand of a binary operation comes from the operand input or from the immediate field, chosen by a select bit. Unary operations and all shifts and rotates read only the accumulator. Compare and bit test compute a result for the flags and never write the accumulator. The block has no state machine: its only state is the accumulator and the two flags. Each clock edge either applies the decoded instruction or, when the group bit is low, keeps all three unchanged.

Instruction fields: `grp_i` = 1 marks a data-manipulation instruction. `code_i` selects the operation class: 0 add, 1 subtract, 2 logic, 3 compare, 4 unary, 5 left shift, 6 right shift, 7 bit test. `type_i` selects the variant within the class. `ld_i` bit 0 enables the accumulator write, bit 1 the carry write, and bit 2 the zero write. `sel_imm_i` = 1 takes `imm_i` as the second operand and 0 takes `opnd_i`.

Top module: `acc_eu`

## Requirements
- R1: An active-low asynchronous reset (`rst_n` = 0) clears the accumulator, the carry flag and the zero flag to 0.
- R2: When `grp_i` = 0, the accumulator and both flags keep their values, whatever the other fields are.
- R3: Code 0 adds the second operand to the accumulator. With `type_i[0]` = 1 it also adds the current carry flag. The carry result is the carry out of bit W-1.
- R4: Code 1 subtracts the second operand from the accumulator. With `type_i[0]` = 1 it also subtracts the current carry flag as a borrow. The carry result is 1 when the subtrahend, including any borrow-in, exceeds the accumulator.
- R5: Code 3 computes the same difference and carry as code 1, including the `type_i[0]` borrow-in, and never writes the accumulator.
- R6: Code 2 with `type_i` 0 gives AND, 1 gives OR, 2 gives XOR and 3 gives AND. Code 7 computes AND for the flags only and never writes the accumulator. Both codes give a carry result of 0.
- R7: Code 4 acts on the accumulator alone. `type_i` 0 is NOT with carry 0. Type 1 is increment, with carry 1 when the accumulator was all ones. Type 2 is decrement, with carry 1 when it was zero. Type 3 is two's complement, with carry 1 when it was non-zero.
- R8: Code 5 shifts left by one bit. `type_i` 0 and 1 fill with 0, type 2 rotates bit W-1 into bit 0, and type 3 moves the old carry into bit 0. The carry result is the old bit W-1.
- R9: Code 6 shifts right by one bit. `type_i` 0 fills with 0, type 1 copies bit W-1, type 2 rotates bit 0 into bit W-1, and type 3 moves the old carry into bit W-1. The carry result is the old bit 0.
- R10: `ld_i[0]`, `ld_i[1]` and `ld_i[2]` independently gate the writes to the accumulator, the carry flag and the zero flag. A target whose enable is 0 keeps its value.
- R11: `sel_imm_i` = 1 makes `imm_i` the second operand, and `sel_imm_i` = 0 makes `opnd_i` the second operand.
- R12: The zero-flag result is 1 exactly when the computed result is all zeros. This holds even when the accumulator write is disabled or blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_i | input | 1 | 1 = data-manipulation instruction |
| code_i | input | 3 | Operation class |
| type_i | input | 2 | Variant within the class |
| ld_i | input | 3 | Write enables: bit 0 accumulator, bit 1 carry, bit 2 zero |
| sel_imm_i | input | 1 | Second operand select: 1 immediate, 0 operand input |
| opnd_i | input | W | Register operand |
| imm_i | input | W | Immediate data |
| acc_o | output | W | Accumulator |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |

## Verification
Additions and subtractions are run on operand pairs that do and do not cross the W-bit boundary, with and without carry-in. This separates the carry-in path from the carry-out and borrow detection. Compare and bit test are given operands that produce zero and non-zero results, which shows that the flags move while the accumulator stays put. Shifts and rotates start from patterns with both end bits set and with a carry held from a previous instruction, so that fill bits, rotated bits and carry-through paths each give a different answer. Partial write-enable masks, an idle group bit and a changed operand select each leave a distinct signature on the three outputs.

// File: rtl/acc_eu_pkg.sv
package acc_eu_pkg;

    localparam int CODE_W = 3;
    localparam int TYPE_W = 2;
    localparam int LD_W   = 3;

    localparam int LD_ACC = 0;
    localparam int LD_CF  = 1;
    localparam int LD_ZF  = 2;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_LOGIC = 3'd2,
        OP_CMP   = 3'd3,
        OP_UNARY = 3'd4,
        OP_SHL   = 3'd5,
        OP_SHR   = 3'd6,
        OP_TEST  = 3'd7
    } op_code_e;

    typedef enum logic [1:0] {
        SH_UNARY = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_NONE  = 2'd3
    } sh_class_e;

endpackage

// File: rtl/acc_eu_opmux.sv
module acc_eu_opmux #(
    parameter int W = 8
) (
    input  logic         sel_imm,
    input  logic [W-1:0] reg_val,
    input  logic [W-1:0] imm_val,
    output logic [W-1:0] b_out
);
    always_comb begin
        b_out = sel_imm ? imm_val : reg_val;
    end
endmodule

// File: rtl/acc_eu_arith.sv
module acc_eu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         use_cin,
    input  logic         do_sub,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int XW = W + 1;

    logic [XW-1:0] ext;
    logic [XW-1:0] cin_ext;

    always_comb begin
        cin_ext = {{W{1'b0}}, cin & use_cin};
        if (do_sub) begin
            ext = {1'b0, a} - {1'b0, b} - cin_ext;
        end else begin
            ext = {1'b0, a} + {1'b0, b} + cin_ext;
        end
        res  = ext[W-1:0];
        cout = ext[W];
    end
endmodule

// File: rtl/acc_eu_logic.sv
module acc_eu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    input  logic         force_and,
    output logic [W-1:0] res
);
    always_comb begin
        if (force_and) begin
            res = a & b;
        end else begin
            unique case (fn)
                2'd1:    res = a | b;
                2'd2:    res = a ^ b;
                default: res = a & b;
            endcase
        end
    end
endmodule

// File: rtl/acc_eu_shift.sv
module acc_eu_shift
    import acc_eu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  sh_class_e    cls,
    input  logic [1:0]   fn,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ZERO = {W{1'b0}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        res  = a;
        cout = 1'b0;
        unique case (cls)
            SH_UNARY: begin
                unique case (fn)
                    2'd0: begin res = ~a;        cout = 1'b0;        end
                    2'd1: begin res = a + ONE;   cout = (a == ONES); end
                    2'd2: begin res = a - ONE;   cout = (a == ZERO); end
                    default: begin res = ZERO - a; cout = (a != ZERO); end
                endcase
            end
            SH_LEFT: begin
                cout = a[W-1];
                unique case (fn)
                    2'd2:    res = {a[W-2:0], a[W-1]};
                    2'd3:    res = {a[W-2:0], cin};
                    default: res = {a[W-2:0], 1'b0};
                endcase
            end
            SH_RIGHT: begin
                cout = a[0];
                unique case (fn)
                    2'd1:    res = {a[W-1], a[W-1:1]};
                    2'd2:    res = {a[0], a[W-1:1]};
                    2'd3:    res = {cin, a[W-1:1]};
                    default: res = {1'b0, a[W-1:1]};
                endcase
            end
            default: begin
                res  = a;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/acc_eu.sv
module acc_eu
    import acc_eu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grp_i,
    input  logic [CODE_W-1:0]    code_i,
    input  logic [TYPE_W-1:0]    type_i,
    input  logic [LD_W-1:0]      ld_i,
    input  logic                 sel_imm_i,
    input  logic [W-1:0]         opnd_i,
    input  logic [W-1:0]         imm_i,
    output logic [W-1:0]         acc_o,
    output logic                 cf_o,
    output logic                 zf_o
);
    op_code_e     op;
    sh_class_e    sh_cls;
    logic [W-1:0] acc_q;
    logic         cf_q;
    logic         zf_q;
    logic [W-1:0] b_val;
    logic [W-1:0] ar_res, lg_res, sh_res;
    logic         ar_c, sh_c;
    logic [W-1:0] res;
    logic         res_c;
    logic         res_z;
    logic         acc_wr;

    assign op = op_code_e'(code_i);

    always_comb begin
        unique case (op)
            OP_UNARY: sh_cls = SH_UNARY;
            OP_SHL:   sh_cls = SH_LEFT;
            OP_SHR:   sh_cls = SH_RIGHT;
            default:  sh_cls = SH_NONE;
        endcase
    end

    acc_eu_opmux #(.W(W)) u_opmux (
        .sel_imm (sel_imm_i),
        .reg_val (opnd_i),
        .imm_val (imm_i),
        .b_out   (b_val)
    );

    acc_eu_arith #(.W(W)) u_arith (
        .a       (acc_q),
        .b       (b_val),
        .cin     (cf_q),
        .use_cin (type_i[0]),
        .do_sub  (op != OP_ADD),
        .res     (ar_res),
        .cout    (ar_c)
    );

    acc_eu_logic #(.W(W)) u_logic (
        .a         (acc_q),
        .b         (b_val),
        .fn        (type_i),
        .force_and (op == OP_TEST),
        .res       (lg_res)
    );

    acc_eu_shift #(.W(W)) u_shift (
        .a    (acc_q),
        .cin  (cf_q),
        .cls  (sh_cls),
        .fn   (type_i),
        .res  (sh_res),
        .cout (sh_c)
    );

    // Result selection and write gating
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP: begin res = ar_res; res_c = ar_c; end
            OP_LOGIC, OP_TEST:      begin res = lg_res; res_c = 1'b0; end
            default:                begin res = sh_res; res_c = sh_c; end
        endcase
        res_z  = (res == '0);
        acc_wr = ld_i[LD_ACC] && (op != OP_CMP) && (op != OP_TEST);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cf_q  <= 1'b0;
            zf_q  <= 1'b0;
        end else if (grp_i) begin
            if (acc_wr)       acc_q <= res;
            if (ld_i[LD_CF])  cf_q  <= res_c;
            if (ld_i[LD_ZF])  zf_q  <= res_z;
        end
    end

    // Outputs
    always_comb begin
        acc_o = acc_q;
        cf_o  = cf_q;
        zf_o  = zf_q;
    end
endmodule

// File: rtl/acc_eu_chk.sv
module acc_eu_chk
    import acc_eu_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grp_i,
    input logic [CODE_W-1:0] code_i,
    input logic [LD_W-1:0]   ld_i,
    input logic [W-1:0]      acc_o,
    input logic              cf_o,
    input logic              zf_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0) && !cf_o && !zf_o);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_i |=> $stable(acc_o) && $stable(cf_o) && $stable(zf_o));

    a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_i && code_i == OP_CMP) |=> $stable(acc_o));

    a_r6_test_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_i && code_i == OP_TEST) |=> $stable(acc_o));

    a_r10_acc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_i && !ld_i[LD_ACC]) |=> $stable(acc_o));

    a_r10_cf_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_i && !ld_i[LD_CF]) |=> $stable(cf_o));

    a_r10_zf_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_i && !ld_i[LD_ZF]) |=> $stable(zf_o));

    a_r12_zf_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_i && ld_i[LD_ACC] && ld_i[LD_ZF] && code_i != OP_CMP && code_i != OP_TEST)
        |=> (zf_o == (acc_o == '0)));
endmodule

bind acc_eu acc_eu_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .grp_i  (grp_i),
    .code_i (code_i),
    .ld_i   (ld_i),
    .acc_o  (acc_o),
    .cf_o   (cf_o),
    .zf_o   (zf_o)
);

// File: tb/acc_eu_tb.sv
module acc_eu_tb;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] acc;
        logic         cf;
        logic         zf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         grp_i = 1'b0;
    logic [2:0]   code_i = '0;
    logic [1:0]   type_i = '0;
    logic [2:0]   ld_i = '0;
    logic         sel_imm_i = 1'b0;
    logic [W-1:0] opnd_i = '0;
    logic [W-1:0] imm_i = '0;
    logic [W-1:0] acc_o;
    logic         cf_o;
    logic         zf_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    logic [W-1:0] m_acc = '0;
    logic         m_cf  = 1'b0;
    logic         m_zf  = 1'b0;

    always #5 clk = ~clk;

    acc_eu #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .grp_i(grp_i), .code_i(code_i),
        .type_i(type_i), .ld_i(ld_i), .sel_imm_i(sel_imm_i),
        .opnd_i(opnd_i), .imm_i(imm_i), .acc_o(acc_o), .cf_o(cf_o), .zf_o(zf_o)
    );

    // Reference model built from the requirements
    task automatic model(input bit g, input logic [2:0] c, input logic [1:0] t,
                         input logic [2:0] ld, input logic [W-1:0] b);
        logic [W:0]   x;
        logic [W-1:0] a, r;
        logic         co;
        a = m_acc; r = '0; co = 1'b0;
        case (c)
            3'd0: begin x = {1'b0, a} + {1'b0, b} + (t[0] ? m_cf : 1'b0); r = x[W-1:0]; co = x[W]; end
            3'd1, 3'd3: begin x = {1'b0, a} - {1'b0, b} - (t[0] ? m_cf : 1'b0); r = x[W-1:0]; co = x[W]; end
            3'd2: r = (t == 2'd1) ? (a | b) : (t == 2'd2) ? (a ^ b) : (a & b);
            3'd7: r = a & b;
            3'd4: case (t)
                2'd0: r = ~a;
                2'd1: begin r = a + 1'b1; co = (a == '1); end
                2'd2: begin r = a - 1'b1; co = (a == '0); end
                default: begin r = -a; co = (a != '0); end
            endcase
            3'd5: begin
                co = a[W-1];
                r = (t == 2'd2) ? {a[W-2:0], a[W-1]} : (t == 2'd3) ? {a[W-2:0], m_cf} : {a[W-2:0], 1'b0};
            end
            default: begin
                co = a[0];
                r = (t == 2'd1) ? {a[W-1], a[W-1:1]} : (t == 2'd2) ? {a[0], a[W-1:1]}
                  : (t == 2'd3) ? {m_cf, a[W-1:1]} : {1'b0, a[W-1:1]};
            end
        endcase
        if (g) begin
            if (ld[0] && c != 3'd3 && c != 3'd7) m_acc = r;
            if (ld[1]) m_cf = co;
            if (ld[2]) m_zf = (r == '0);
        end
    endtask

    // Driver: apply one instruction and push the expected outcome
    task automatic issue(input string tag, input bit g, input logic [2:0] c,
                         input logic [1:0] t, input logic [2:0] ld, input bit si,
                         input logic [W-1:0] op, input logic [W-1:0] im);
        exp_t e;
        @(negedge clk);
        grp_i = g; code_i = c; type_i = t; ld_i = ld;
        sel_imm_i = si; opnd_i = op; imm_i = im;
        model(g, c, t, ld, si ? im : op);
        e.acc = m_acc; e.cf = m_cf; e.zf = m_zf; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare one cycle after each applied instruction
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (acc_o !== e.acc || cf_o !== e.cf || zf_o !== e.zf) begin
                    n_fail++;
                    $display("FAIL %s: acc=%h cf=%b zf=%b expected acc=%h cf=%b zf=%b",
                             e.tag, acc_o, cf_o, zf_o, e.acc, e.cf, e.zf);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (acc_o !== '0 || cf_o !== 1'b0 || zf_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: acc=%h cf=%b zf=%b expected acc=00 cf=0 zf=0", acc_o, cf_o, zf_o);
        end
        rst_n = 1'b1;

        // R3 / R11 add
        issue("R3", 1, 3'd0, 2'd0, 3'b111, 1, 8'h00, 8'h30);
        issue("R3", 1, 3'd0, 2'd0, 3'b111, 1, 8'h00, 8'hE0);
        issue("R3", 1, 3'd0, 2'd1, 3'b111, 1, 8'h00, 8'h05);
        issue("R11", 1, 3'd0, 2'd0, 3'b111, 0, 8'h22, 8'hFF);
        issue("R11", 1, 3'd0, 2'd0, 3'b111, 1, 8'h22, 8'h01);
        // R4 subtract
        issue("R4", 1, 3'd1, 2'd0, 3'b111, 1, 8'h00, 8'h40);
        issue("R4", 1, 3'd1, 2'd1, 3'b111, 1, 8'h00, 8'h08);
        issue("R4", 1, 3'd1, 2'd0, 3'b111, 0, 8'h0F, 8'h00);
        // R5 compare
        issue("R5", 1, 3'd3, 2'd0, 3'b111, 1, 8'h00, m_acc);
        issue("R5", 1, 3'd3, 2'd0, 3'b111, 1, 8'h00, 8'hFF);
        issue("R5", 1, 3'd3, 2'd1, 3'b111, 1, 8'h00, 8'h01);
        // R6 logic and test
        issue("R6", 1, 3'd2, 2'd1, 3'b111, 1, 8'h00, 8'hA5);
        issue("R6", 1, 3'd2, 2'd0, 3'b111, 1, 8'h00, 8'h3C);
        issue("R6", 1, 3'd2, 2'd2, 3'b111, 1, 8'h00, 8'hFF);
        issue("R6", 1, 3'd2, 2'd3, 3'b111, 1, 8'h00, 8'h0F);
        issue("R6", 1, 3'd7, 2'd0, 3'b111, 1, 8'h00, 8'h00);
        issue("R6", 1, 3'd7, 2'd2, 3'b111, 1, 8'h00, 8'hFF);
        // R7 unary
        issue("R7", 1, 3'd2, 2'd1, 3'b111, 1, 8'h00, 8'hFF);
        issue("R7", 1, 3'd4, 2'd1, 3'b111, 1, 8'h00, 8'h00);
        issue("R7", 1, 3'd4, 2'd2, 3'b111, 1, 8'h00, 8'h00);
        issue("R7", 1, 3'd4, 2'd0, 3'b111, 1, 8'h00, 8'h00);
        issue("R7", 1, 3'd4, 2'd3, 3'b111, 1, 8'h00, 8'h00);
        issue("R7", 1, 3'd4, 2'd1, 3'b111, 1, 8'h00, 8'h00);
        // R8 left shifts from 0x81
        issue("R8", 1, 3'd2, 2'd0, 3'b111, 1, 8'h00, 8'h00);
        issue("R8", 1, 3'd0, 2'd0, 3'b111, 1, 8'h00, 8'h81);
        issue("R8", 1, 3'd5, 2'd0, 3'b111, 1, 8'h00, 8'h00);
        issue("R8", 1, 3'd5, 2'd1, 3'b111, 1, 8'h00, 8'h00);
        issue("R8", 1, 3'd2, 2'd1, 3'b111, 1, 8'h00, 8'h81);
        issue("R8", 1, 3'd5, 2'd2, 3'b111, 1, 8'h00, 8'h00);
        issue("R8", 1, 3'd5, 2'd3, 3'b111, 1, 8'h00, 8'h00);
        issue("R8", 1, 3'd5, 2'd3, 3'b111, 1, 8'h00, 8'h00);
        // R9 right shifts
        issue("R9", 1, 3'd2, 2'd3, 3'b111, 1, 8'h00, 8'h81);
        issue("R9", 1, 3'd6, 2'd0, 3'b111, 1, 8'h00, 8'h00);
        issue("R9", 1, 3'd2, 2'd1, 3'b111, 1, 8'h00, 8'h81);
        issue("R9", 1, 3'd6, 2'd1, 3'b111, 1, 8'h00, 8'h00);
        issue("R9", 1, 3'd6, 2'd2, 3'b111, 1, 8'h00, 8'h00);
        issue("R9", 1, 3'd6, 2'd3, 3'b111, 1, 8'h00, 8'h00);
        issue("R9", 1, 3'd6, 2'd3, 3'b111, 1, 8'h00, 8'h00);
        // R10 write enables
        issue("R10", 1, 3'd0, 2'd0, 3'b001, 1, 8'h00, 8'hFF);
        issue("R10", 1, 3'd0, 2'd0, 3'b010, 1, 8'h00, 8'hFF);
        issue("R10", 1, 3'd2, 2'd0, 3'b100, 1, 8'h00, 8'h00);
        issue("R10", 1, 3'd4, 2'd1, 3'b011, 1, 8'h00, 8'h00);
        // R12 zero flag from an unwritten result
        issue("R12", 1, 3'd1, 2'd0, 3'b100, 0, m_acc, 8'h00);
        issue("R12", 1, 3'd2, 2'd2, 3'b110, 1, 8'h00, 8'h01);
        // R2 idle group bit
        issue("R2", 0, 3'd0, 2'd1, 3'b111, 1, 8'h00, 8'h55);
        issue("R2", 0, 3'd4, 2'd3, 3'b111, 0, 8'hAA, 8'h00);
        issue("R2", 1, 3'd0, 2'd0, 3'b111, 1, 8'h00, 8'h01);

        @(negedge clk);
        grp_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule